// File: doc/BRIEF.md
# Sleep Entry and Recovery Sequencer

This block controls the low-power sleep state of a synchronous memory. It takes an asynchronous, active-high sleep request. The request passes through a synchronizer, and a three-state controller turns it into a sleep-active indication. While that indication is high, every command input is masked, the data-output drivers are told to go high-impedance, and the cycle decoder is told to treat the part as deselected. The block never touches the stored data and keeps no copy of it, so the array contents stay unchanged across sleep.

When the request drops, the controller does not go straight back to normal operation. It first passes through a recovery window whose length is a parameter counted in clock cycles. Inside that window, reads and deselects reach the core. A write is dropped, and an error pulse reports the dropped write. If the request rises again during recovery, the controller goes back to sleep. A burst-in-progress flag from the datapath shows whether sleep was requested while an operation was still pending.

Top module: `sleep_seq`

## Requirements
- R1: After reset the block is in normal operation: sleep_active, recovering and wr_block_err are 0, and out_hiz and force_desel are 0.
- R2: In normal operation each command passes unchanged: core_sel = cmd_sel, core_wr = cmd_sel & cmd_wr, and core_addr = cmd_addr while core_sel is 1 (0 otherwise).
- R3: sleep_active goes to 1 after the second rising clock edge at which sleep_req is 1, and is still 0 after the first of those edges.
- R4: While sleep_active is 1, out_hiz and force_desel are 1, and core_sel, core_wr and core_addr are 0 whatever cmd_sel, cmd_wr, cmd_addr and burst_busy do.
- R5: sleep_active stays 1 for as long as sleep_req stays 1.
- R6: After the second rising edge with sleep_req at 0 following sleep, recovering is 1 for exactly RECOV_CYC cycles (6 by default) and sleep_active is 0. After that, normal operation resumes.
- R7: During recovery a read (cmd_sel=1, cmd_wr=0) or a deselect (cmd_sel=0) passes to the core as in R2.
- R8: During recovery a write (cmd_sel=1, cmd_wr=1) is blocked: core_sel and core_wr stay 0. wr_block_err is then 1 for exactly the one cycle after the clock edge that sampled the write.
- R9: If sleep_req is 1 at two rising edges during recovery, the block returns to sleep: recovering is still 1 after the first edge and sleep_active is 1 after the second.
- R10: Sleep may only be recognised from normal operation while burst_busy is 0. An entry under that condition proceeds as R3 describes.
- R11: sleep_active and recovering are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| burst_busy | input | 1 | Datapath still has an operation in progress |
| cmd_sel | input | 1 | Decoded chip select for this cycle |
| cmd_wr | input | 1 | Decoded write for this cycle |
| cmd_addr | input | ADDR_W | Command address |
| sleep_active | output | 1 | Block is asleep |
| recovering | output | 1 | Recovery window is running |
| out_hiz | output | 1 | Force data outputs to high impedance |
| force_desel | output | 1 | Cycle decoder must treat the part as deselected |
| core_sel | output | 1 | Filtered select to the core |
| core_wr | output | 1 | Filtered write to the core |
| core_addr | output | ADDR_W | Filtered address, zero when not selected |
| wr_block_err | output | 1 | One-cycle pulse after a write blocked in recovery |

## Verification
The command filter is combinational, so its outputs are due in the same cycle as the command. The error pulse is due one edge after the blocked write. Entering sleep and leaving it each take two edges, because the request passes one synchronizer flop and then the state register. The recovery window spans RECOV_CYC edges after that. The driver records each expectation together with the cycle number at which it falls due. The monitor compares the outputs a quarter period after that cycle's rising edge, while inputs change only on falling edges, so a check is made neither one edge early nor one edge late.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ASLEEP  = 2'd1,
    ST_RECOVER = 2'd2
  } slp_state_e;

  // Next state of the sleep controller.
  function automatic slp_state_e slp_next(slp_state_e cur, logic req_seen,
                                          logic recov_last);
    slp_state_e nxt;
    case (cur)
      ST_AWAKE:   nxt = req_seen ? ST_ASLEEP : ST_AWAKE;
      ST_ASLEEP:  nxt = req_seen ? ST_ASLEEP : ST_RECOVER;
      ST_RECOVER: begin
        if (req_seen)        nxt = ST_ASLEEP;
        else if (recov_last) nxt = ST_AWAKE;
        else                 nxt = ST_RECOVER;
      end
      default:    nxt = ST_AWAKE;
    endcase
    return nxt;
  endfunction

  // A command reaches the core unless asleep, or a write during recovery.
  function automatic logic cmd_pass(logic asleep, logic recov, logic sel,
                                    logic wr);
    return sel & ~asleep & ~(recov & wr);
  endfunction

  function automatic logic write_blocked(logic recov, logic sel, logic wr);
    return recov & sel & wr;
  endfunction

endpackage

// File: rtl/sleep_req_sync.sv
module sleep_req_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sleep_recov_timer.sv
module sleep_recov_timer #(
  parameter int RECOV_CYC = 6,
  localparam int CNT_W = $clog2(RECOV_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  output logic             last,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RECOV_CYC);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= LOAD_VAL;
    else if (run && cnt != '0)  cnt <= cnt - ONE;
  end

  assign last = run && (cnt == ONE);
endmodule

// File: rtl/sleep_cmd_gate.sv
module sleep_cmd_gate
  import sleep_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asleep,
  input  logic              recov,
  input  logic              cmd_sel,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              core_sel,
  output logic              core_wr,
  output logic [ADDR_W-1:0] core_addr,
  output logic              blocked_evt,
  output logic              err_q
);
  always_comb begin
    core_sel    = cmd_pass(asleep, recov, cmd_sel, cmd_wr);
    core_wr     = core_sel & cmd_wr;
    core_addr   = core_sel ? cmd_addr : '0;
    blocked_evt = write_blocked(recov, cmd_sel, cmd_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= blocked_evt;
  end
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 1,
  parameter int RECOV_CYC   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              burst_busy,
  input  logic              cmd_sel,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              sleep_active,
  output logic              recovering,
  output logic              out_hiz,
  output logic              force_desel,
  output logic              core_sel,
  output logic              core_wr,
  output logic [ADDR_W-1:0] core_addr,
  output logic              wr_block_err
);
  localparam int CNT_W = $clog2(RECOV_CYC + 1);

  slp_state_e       state, state_nxt;
  logic             req_seen;
  logic             recov_last;
  logic [CNT_W-1:0] recov_cnt;
  logic             entry_evt;
  logic             exit_evt;
  logic             blocked_evt;
  logic             busy_at_entry;

  sleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(sleep_req),
    .q_sync (req_seen)
  );

  assign state_nxt     = slp_next(state, req_seen, recov_last);
  assign entry_evt     = (state == ST_AWAKE) && req_seen;
  assign exit_evt      = (state == ST_ASLEEP) && !req_seen;
  assign busy_at_entry = entry_evt && burst_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_AWAKE;
    else        state <= state_nxt;
  end

  sleep_recov_timer #(.RECOV_CYC(RECOV_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (exit_evt),
    .run  (state == ST_RECOVER),
    .last (recov_last),
    .cnt  (recov_cnt)
  );

  assign sleep_active = (state == ST_ASLEEP);
  assign recovering   = (state == ST_RECOVER);
  assign out_hiz      = sleep_active;
  assign force_desel  = sleep_active;

  sleep_cmd_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .asleep     (sleep_active),
    .recov      (recovering),
    .cmd_sel    (cmd_sel),
    .cmd_wr     (cmd_wr),
    .cmd_addr   (cmd_addr),
    .core_sel   (core_sel),
    .core_wr    (core_wr),
    .core_addr  (core_addr),
    .blocked_evt(blocked_evt),
    .err_q      (wr_block_err)
  );
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk
  import sleep_seq_pkg::*;
#(
  parameter int RECOV_CYC = 6
) (
  input logic       clk,
  input logic       rst_n,
  input slp_state_e state,
  input logic       entry_evt,
  input logic       busy_at_entry,
  input logic       cmd_sel,
  input logic       cmd_wr,
  input logic       sleep_active,
  input logic       recovering,
  input logic       out_hiz,
  input logic       force_desel,
  input logic       core_sel,
  input logic       core_wr,
  input logic       wr_block_err
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= 0;
    else if (recovering) run_len <= run_len + 1;
    else                 run_len <= 0;
  end

  // R3
  entry_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt |=> sleep_active);

  // R4
  asleep_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> (out_hiz && force_desel && !core_sel && !core_wr));

  // R6
  exit_enters_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_active) |-> recovering);

  // R6
  recovery_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> (run_len < RECOV_CYC));

  // R6
  recovery_full_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(recovering) && !sleep_active) |-> (run_len == RECOV_CYC));

  // R8
  write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> !core_wr);

  // R8
  blocked_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && cmd_sel && cmd_wr) |=> wr_block_err);

  // R10
  no_entry_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_at_entry);

  // R11
  asleep_recover_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_active && recovering));

  // R11
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);
endmodule

bind sleep_seq sleep_seq_chk #(.RECOV_CYC(RECOV_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state        (state),
  .entry_evt    (entry_evt),
  .busy_at_entry(busy_at_entry),
  .cmd_sel      (cmd_sel),
  .cmd_wr       (cmd_wr),
  .sleep_active (sleep_active),
  .recovering   (recovering),
  .out_hiz      (out_hiz),
  .force_desel  (force_desel),
  .core_sel     (core_sel),
  .core_wr      (core_wr),
  .wr_block_err (wr_block_err)
);

// File: tb/tb_sleep_seq.sv
`timescale 1ns/1ps
module tb_sleep_seq;
  localparam int AW = 8;
  localparam int OW = 7 + AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, burst_busy = 1'b0, cmd_sel = 1'b0, cmd_wr = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic sleep_active, recovering, out_hiz, force_desel, core_sel, core_wr, wr_block_err;
  logic [AW-1:0] core_addr;

  sleep_seq #(.ADDR_W(AW), .SYNC_STAGES(1), .RECOV_CYC(6)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .burst_busy(burst_busy),
    .cmd_sel(cmd_sel), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .sleep_active(sleep_active), .recovering(recovering), .out_hiz(out_hiz),
    .force_desel(force_desel), .core_sel(core_sel), .core_wr(core_wr),
    .core_addr(core_addr), .wr_block_err(wr_block_err)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    logic [OW-1:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected vector: {asleep, recov, hiz, desel, sel, wr, err, addr}.
  // Asleep implies hiz and desel (R4), so the helper builds them from it.
  function automatic logic [OW-1:0] mk(logic sa, logic rc, logic sel, logic wr,
                                       logic err, logic [AW-1:0] a);
    return {sa, rc, sa, sa, sel, wr, err, a};
  endfunction

  task automatic drive(logic rq, logic bz, logic s, logic w, logic [AW-1:0] a);
    @(negedge clk);
    sleep_req = rq; burst_busy = bz; cmd_sel = s; cmd_wr = w; cmd_addr = a;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_in(int k, logic [OW-1:0] e, string tag);
    item_t it;
    it.due = cyc + k; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: sample a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          logic [OW-1:0] got;
          got = {sleep_active, recovering, out_hiz, force_desel, core_sel,
                 core_wr, wr_block_err, core_addr};
          checks++;
          if (got !== sb[i].exp) begin
            errors++;
            $display("FAIL %s cycle %0d got %b expected %b", sb[i].tag, cyc,
                     got, sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    drive(0, 0, 0, 0, 8'h00); expect_in(1, mk(0,0,0,0,0,8'h00), "R1");
    // R2 normal read and write pass through
    drive(0, 1, 1, 0, 8'h3C); expect_in(1, mk(0,0,1,0,0,8'h3C), "R2");
    drive(0, 0, 1, 1, 8'h5A); expect_in(1, mk(0,0,1,1,0,8'h5A), "R2");
    drive(0, 0, 0, 0, 8'h00);

    // R3 / R10 entry with busy low: not asleep after one edge, asleep after two
    drive(1, 0, 1, 0, 8'h11);
    expect_in(1, mk(0,0,1,0,0,8'h11), "R3");
    expect_in(2, mk(1,0,0,0,0,8'h00), "R10");
    idle(1);
    // R4 inputs masked while asleep; R5 sleep persists
    drive(1, 1, 1, 1, 8'h77);
    expect_in(1, mk(1,0,0,0,0,8'h00), "R4");
    expect_in(5, mk(1,0,0,0,0,8'h00), "R5");
    idle(5);
    drive(1, 0, 0, 0, 8'h00); expect_in(1, mk(1,0,0,0,0,8'h00), "R5");

    // R6 / R7 exit: recovery for exactly 6 cycles, reads pass
    drive(0, 0, 1, 0, 8'h22);
    expect_in(1, mk(1,0,0,0,0,8'h00), "R6");
    expect_in(2, mk(0,1,1,0,0,8'h22), "R7");
    expect_in(7, mk(0,1,1,0,0,8'h22), "R6");
    expect_in(8, mk(0,0,1,0,0,8'h22), "R6");
    idle(8);

    // Second sleep, then R8 blocked write in recovery
    drive(1, 0, 0, 0, 8'h00); expect_in(2, mk(1,0,0,0,0,8'h00), "R3");
    idle(3);
    drive(0, 0, 0, 0, 8'h00);
    idle(1);
    drive(0, 0, 1, 1, 8'h44); expect_in(1, mk(0,1,0,0,1,8'h00), "R8");
    drive(0, 0, 0, 0, 8'h00); expect_in(1, mk(0,1,0,0,0,8'h00), "R8");
    drive(0, 0, 1, 0, 8'h66);
    expect_in(1, mk(0,1,1,0,0,8'h66), "R7");
    expect_in(3, mk(0,1,1,0,0,8'h66), "R6");
    expect_in(4, mk(0,0,1,0,0,8'h66), "R6");
    idle(4);
    drive(0, 0, 1, 1, 8'h99); expect_in(1, mk(0,0,1,1,0,8'h99), "R2");

    // R9 request returns during recovery
    drive(1, 0, 0, 0, 8'h00); expect_in(2, mk(1,0,0,0,0,8'h00), "R3");
    idle(2);
    drive(0, 0, 0, 0, 8'h00);
    idle(1);
    drive(1, 0, 1, 0, 8'h2B);
    expect_in(1, mk(0,1,1,0,0,8'h2B), "R9");
    expect_in(2, mk(1,0,0,0,0,8'h00), "R9");
    idle(1);
    drive(0, 0, 0, 0, 8'h00); expect_in(10, mk(0,0,0,0,0,8'h00), "R6");
    idle(12);

    if (sb.size() != 0) begin
      errors += sb.size();
      checks += sb.size();
      $display("FAIL scoreboard %0d unchecked got %0d expected 0", sb.size(), sb.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule